// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block gathers a parameterised number of level-sensitive interrupt request lines (64 by default) and raises one interrupt line toward the processor while any source qualifies. A source qualifies when its request line is high, its enable bit is set and its 4-bit priority is strictly above the current mask threshold. Software controls it through a small 32-bit register window, written with a single-cycle write strobe and read combinationally by address.

Enables are changed one source at a time: a source number written to one address sets that source's enable, and written to another address clears it. Priorities are packed eight to a word. A vector word reports the winning source and its level in one read, and reads as all ones (negative when seen as signed) when nothing qualifies. An interrupt handler saves the mask, raises it to the level it is servicing so that only higher levels can win, and then puts the saved value back.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset all enable bits and priority fields are 0, the mask reads back as 0x1F, the vector word reads 0xFFFF_FFFF and `irq_o` is low.
- R2: Writing source number n (in data bits [IDX_W-1:0]) to address 0x04 sets the enable of source n and leaves every other enable unchanged.
- R3: Writing source number n to address 0x08 clears the enable of source n and leaves every other enable unchanged.
- R4: With G = NUM_SRC/8 priority words, the word for sources 8g..8g+7 sits at address 0x20 + 4·(G−1−g), so source 0 is in the highest word; source n's field is data bits [4·(n mod 8)+3 : 4·(n mod 8)]. Each word reads back what was written.
- R5: The vector word, at address 0x0C, holds the winning source number in bits 31:16 and its priority in bits 15:0.
- R6: When no source qualifies, the vector word reads 0xFFFF_FFFF.
- R7: Among qualifying sources, the one with the numerically highest priority wins.
- R8: Among qualifying sources that share the highest priority, the lowest-numbered one wins.
- R9: The mask register at address 0x00 holds a 5-bit two's-complement level (data bits 4:0, read back zero-extended); a source qualifies only if its priority is greater than that level, so 0x1F (−1) blocks nothing and 0x0F blocks everything.
- R10: `irq_o` goes high one clock edge after some source qualifies and low one clock edge after none does.
- R11: Sources are level-sensitive: the vector word follows the request lines in the same cycle, and a source whose request falls stops winning at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | NUM_SRC | Level request lines, one per source |
| bus_wr_i | input | 1 | Write strobe for the register window |
| bus_addr_i | input | 8 | Byte address for writes and reads |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the controller with NUM_SRC = 16, which gives two priority words (0x24 for sources 0–7, 0x20 for 8–15) and a four-level arbitration tree. At that size every source can be enabled and disabled on its own, every mask level from −1 to 15 can be stepped through, and every tie position can be walked, with the expected vector worked out by a plain scan in the bench. A long pseudo-random mix of enable, disable, mask, priority and request changes then compares the vector word and the interrupt line against the same scan after every step.

// File: rtl/intc_pkg.sv
// Package: register addresses shared by the interrupt controller modules.
// Assumes an 8-bit byte address and 32-bit data words.
package intc_pkg;
    localparam int AW = 8;
    localparam int DW = 32;

    localparam logic [AW-1:0] ADDR_MASK    = 8'h00;
    localparam logic [AW-1:0] ADDR_EN_NUM  = 8'h04;
    localparam logic [AW-1:0] ADDR_DIS_NUM = 8'h08;
    localparam logic [AW-1:0] ADDR_VECTOR  = 8'h0C;
    localparam logic [AW-1:0] ADDR_PRIO_LO = 8'h20;

    // Address of the priority word holding group grp; group 0 is highest.
    function automatic logic [AW-1:0] prio_word_addr(input int grp, input int ngrp);
        return ADDR_PRIO_LO + AW'(4 * (ngrp - 1 - grp));
    endfunction
endpackage

// File: rtl/intc_regs.sv
// Module: intc_regs
// Holds the per-source enable bits, packed priority fields and the mask
// threshold. Enables change one source per write, by number. Assumes
// NUM_SRC is a power of two and a multiple of the fields per word.
module intc_regs #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int MASK_W  = PRIO_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [intc_pkg::AW-1:0]          wr_addr,
    input  logic [intc_pkg::DW-1:0]          wr_data,
    output logic [NUM_SRC-1:0]               en_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
    output logic [MASK_W-1:0]                mask_o
);
    import intc_pkg::*;

    localparam int SLOTS = DW / PRIO_W;
    localparam int NGRP  = NUM_SRC / SLOTS;

    logic [NUM_SRC-1:0]             en_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [MASK_W-1:0]              mask_q;
    logic [IDX_W-1:0]               wr_idx;

    assign wr_idx = wr_data[IDX_W-1:0];

    // Set or clear one enable bit selected by the written source number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_addr == ADDR_EN_NUM) begin
            en_q[wr_idx] <= 1'b1;
        end else if (wr_en && wr_addr == ADDR_DIS_NUM) begin
            en_q[wr_idx] <= 1'b0;
        end
    end

    // Load the priority fields of the group whose word address is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_addr == prio_word_addr(i / SLOTS, NGRP)) begin
                    prio_q[i] <= wr_data[(i % SLOTS) * PRIO_W +: PRIO_W];
                end
            end
        end
    end

    // Mask threshold; resets to all ones (-1), which blocks no source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en && wr_addr == ADDR_MASK) begin
            mask_q <= wr_data[MASK_W-1:0];
        end
    end

    assign en_o   = en_q;
    assign prio_o = prio_q;
    assign mask_o = mask_q;

    // R2: an enable write sets exactly the named bit.
    p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_EN_NUM) |=>
        (en_q == ($past(en_q) | (NUM_SRC'(1) << $past(wr_idx)))));

    // R3: a disable write clears exactly the named bit.
    p_disable_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIS_NUM) |=>
        (en_q == ($past(en_q) & ~(NUM_SRC'(1) << $past(wr_idx)))));

    // R4: priorities hold when nothing is written.
    p_prio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prio_q));

    // R9: the mask holds unless its own address is written.
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/intc_arbiter.sv
// Module: intc_arbiter
// Qualifies each source (request, enable, priority above mask) and picks
// the winner through a binary tree; the left (lower-numbered) child wins
// ties. Purely combinational; clk and rst_n only clock the assertions.
// Assumes NUM_SRC is a power of two.
module intc_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int MASK_W  = PRIO_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [MASK_W-1:0]              mask_i,
    output logic                           found_o,
    output logic [IDX_W-1:0]               win_idx_o,
    output logic [PRIO_W-1:0]              win_prio_o
);
    localparam int LEVELS = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] qual;

    // Per-source qualification: signed compare against the 5-bit mask.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
        assign qual[s] = req_i[s] && en_i[s]
                      && ($signed({1'b0, prio_i[s]}) > $signed(mask_i));
    end

    // One generate block per tree level; level 0 holds the leaves.
    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int NL = NUM_SRC >> l;
        logic [NL-1:0]             v;
        logic [NL-1:0][PRIO_W-1:0] p;
        logic [NL-1:0][IDX_W-1:0]  ix;
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < NL; j++) begin : g_n
                assign v[j]  = qual[j];
                assign p[j]  = prio_i[j];
                assign ix[j] = IDX_W'(j);
            end
        end else begin : g_node
            for (genvar j = 0; j < NL; j++) begin : g_n
                logic take_left;
                // Left child (lower numbers) wins unless right is strictly higher.
                assign take_left = g_lvl[l-1].v[2*j]
                    && (!g_lvl[l-1].v[2*j+1] || g_lvl[l-1].p[2*j] >= g_lvl[l-1].p[2*j+1]);
                assign v[j]  = g_lvl[l-1].v[2*j] || g_lvl[l-1].v[2*j+1];
                assign p[j]  = take_left ? g_lvl[l-1].p[2*j]  : g_lvl[l-1].p[2*j+1];
                assign ix[j] = take_left ? g_lvl[l-1].ix[2*j] : g_lvl[l-1].ix[2*j+1];
            end
        end
    end

    assign found_o    = g_lvl[LEVELS].v[0];
    assign win_idx_o  = g_lvl[LEVELS].ix[0];
    assign win_prio_o = g_lvl[LEVELS].p[0];

    // R5: a reported winner is a requesting, enabled source with that level.
    p_winner_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (req_i[win_idx_o] && en_i[win_idx_o]
                     && prio_i[win_idx_o] == win_prio_o));

    // R7 and R8: no qualifying source beats the winner on level or on number.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        p_best_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            qual[s] |-> (found_o && (win_prio_o > prio_i[s]
                        || (win_prio_o == prio_i[s] && int'(win_idx_o) <= s))));
    end
endmodule

// File: rtl/prio_vec_intc.sv
// Module: prio_vec_intc
// Top of the vectored priority interrupt controller: register window,
// arbitration, vector word and the registered interrupt line.
// Assumes NUM_SRC is a power of two, at least 8 and at most 64.
module prio_vec_intc #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_src_i,
    input  logic                     bus_wr_i,
    input  logic [intc_pkg::AW-1:0]  bus_addr_i,
    input  logic [intc_pkg::DW-1:0]  bus_wdata_i,
    output logic [intc_pkg::DW-1:0]  bus_rdata_o,
    output logic                     irq_o
);
    import intc_pkg::*;

    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int MASK_W = PRIO_W + 1;
    localparam int SLOTS  = DW / PRIO_W;
    localparam int NGRP   = NUM_SRC / SLOTS;
    localparam int HALF   = DW / 2;

    logic [NUM_SRC-1:0]             en_w;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
    logic [MASK_W-1:0]              mask_w;
    logic                           found_w;
    logic [IDX_W-1:0]               win_idx_w;
    logic [PRIO_W-1:0]              win_prio_w;
    logic [DW-1:0]                  vec_w;
    logic                           irq_q;

    intc_regs #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W),
        .MASK_W  (MASK_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_i),
        .wr_addr (bus_addr_i),
        .wr_data (bus_wdata_i),
        .en_o    (en_w),
        .prio_o  (prio_w),
        .mask_o  (mask_w)
    );

    intc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W),
        .MASK_W  (MASK_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (irq_src_i),
        .en_i       (en_w),
        .prio_i     (prio_w),
        .mask_i     (mask_w),
        .found_o    (found_w),
        .win_idx_o  (win_idx_w),
        .win_prio_o (win_prio_w)
    );

    // Vector word: winner number high, its level low, all ones when idle.
    assign vec_w = found_w ? {HALF'(win_idx_w), HALF'(win_prio_w)} : '1;

    // Read mux over the mask, vector and priority words.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_MASK) begin
            bus_rdata_o = DW'(mask_w);
        end else if (bus_addr_i == ADDR_VECTOR) begin
            bus_rdata_o = vec_w;
        end
        for (int g = 0; g < NGRP; g++) begin
            if (bus_addr_i == prio_word_addr(g, NGRP)) begin
                bus_rdata_o = prio_w[g*SLOTS +: SLOTS];
            end
        end
    end

    // Interrupt line registered one cycle behind the arbitration result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= found_w;
        end
    end

    assign irq_o = irq_q;

    // R6: with no enabled request the vector word is all ones.
    p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_src_i & en_w) == '0) |-> (vec_w == '1));

    // R10: the line rises one edge after a source qualifies.
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        found_w |=> irq_o);

    // R10: the line falls one edge after no source qualifies.
    p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !found_w |=> !irq_o);
endmodule

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/1ps
module tb_prio_vec_intc;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          wr = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit en_m [N];
    int pr_m [N];
    int mask_m;
    logic [31:0] lfsr = 32'h1234_5678;

    prio_vec_intc #(.NUM_SRC(N), .PRIO_W(4)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (req),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Expected vector by a plain scan: strict > keeps the lowest number on ties.
    function automatic logic [31:0] exp_vec();
        int best = -1;
        int bp = -1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && en_m[i] && pr_m[i] > mask_m && pr_m[i] > bp) begin
                best = i;
                bp = pr_m[i];
            end
        end
        if (best < 0) return 32'hFFFF_FFFF;
        return {16'(best), 16'(bp)};
    endfunction

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_vec(input string tag);
        logic [31:0] v;
        rd_reg(8'h0C, v);
        chk(tag, v, exp_vec());
    endtask

    task automatic check_irq_next(input string tag);
        @(negedge clk);
        #1;
        chk(tag, 32'(irq), 32'(exp_vec() != 32'hFFFF_FFFF));
    endtask

    task automatic set_en(input int s, input bit on);
        en_m[s] = on;
        wr_reg(on ? 8'h04 : 8'h08, 32'(s));
    endtask

    function automatic logic [31:0] group_word(input int g);
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) w[4*k +: 4] = 4'(pr_m[g*8 + k]);
        return w;
    endfunction

    // R4: group 0 at 0x24, group 1 at 0x20 when N = 16.
    task automatic put_prio(input int s, input int p);
        pr_m[s] = p;
        wr_reg((s / 8) == 0 ? 8'h24 : 8'h20, group_word(s / 8));
    endtask

    task automatic set_mask(input int m);
        mask_m = m;
        wr_reg(8'h00, 32'(m & 31));
    endtask

    task automatic set_req(input logic [N-1:0] v);
        @(negedge clk);
        req = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < N; i++) begin en_m[i] = 0; pr_m[i] = 0; end
        mask_m = -1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, with every request line high.
        req = '1;
        rd_reg(8'h0C, d); chk("R1 vector idle", d, 32'hFFFF_FFFF);
        chk("R1 irq low", 32'(irq), 32'd0);
        rd_reg(8'h00, d); chk("R1 mask", d, 32'h1F);
        rd_reg(8'h24, d); chk("R1 prio word 0", d, 32'h0);
        rd_reg(8'h20, d); chk("R1 prio word 1", d, 32'h0);

        // R4: field placement, two patterns, read back both words.
        for (int s = 0; s < N; s++) put_prio(s, (s * 5 + 3) % 16);
        rd_reg(8'h24, d); chk("R4 word 0 pattern A", d, group_word(0));
        rd_reg(8'h20, d); chk("R4 word 1 pattern A", d, group_word(1));
        for (int s = 0; s < N; s++) put_prio(s, (s * 11 + 7) % 16);
        rd_reg(8'h24, d); chk("R4 word 0 pattern B", d, group_word(0));
        rd_reg(8'h20, d); chk("R4 word 1 pattern B", d, group_word(1));

        // R2, R3, R5: each source alone wins with its own field, then drops.
        for (int s = 0; s < N; s++) begin
            set_en(s, 1'b1);
            rd_reg(8'h0C, d); chk("R2 R5 single source", d, {16'(s), 16'(pr_m[s])});
            set_en(s, 1'b0);
            check_vec("R3 single disabled");
        end

        // R2 with others kept: enable one more each step.
        for (int s = 0; s < N; s++) begin
            set_en(s, 1'b1);
            check_vec("R2 cumulative enable");
        end
        // R3 with others kept: disable from the top down.
        for (int s = N - 1; s >= 0; s--) begin
            set_en(s, 1'b0);
            check_vec("R3 cumulative disable");
        end
        for (int s = 0; s < N; s++) set_en(s, 1'b1);

        // R8: equal levels, lowest requesting number wins.
        for (int s = 0; s < N; s++) put_prio(s, 7);
        for (int k = 0; k < N; k++) begin
            set_req(N'('1) << k);
            rd_reg(8'h0C, d); chk("R8 tie lowest", d, {16'(k), 16'd7});
        end

        // R7: distinct levels, level s on source s.
        for (int s = 0; s < N; s++) put_prio(s, s);
        for (int k = 0; k < N; k++) begin
            set_req(N'('1) >> k);
            rd_reg(8'h0C, d); chk("R7 highest level", d, {16'(N - 1 - k), 16'(N - 1 - k)});
        end

        // R9: step every mask level, read back, check several request sets.
        for (int m = -1; m <= 15; m++) begin
            set_mask(m);
            rd_reg(8'h00, d); chk("R9 mask readback", d, 32'(m & 31));
            set_req('1); check_vec("R9 mask all req");
            set_req(16'h00F0); check_vec("R9 mask mid req");
            set_req(16'h8001); check_vec("R9 mask edge req");
        end
        set_mask(-1);

        // R10, R11: line timing on request, disable and mask changes.
        set_req('0);
        @(negedge clk); #1;
        chk("R10 idle", 32'(irq), 32'd0);
        set_req(16'h0010);
        rd_reg(8'h0C, d); chk("R11 vector same cycle", d, {16'd4, 16'd4});
        chk("R10 not yet high", 32'(irq), 32'd0);
        check_irq_next("R10 high after edge");
        set_req('0);
        check_vec("R11 request fell");
        #1; chk("R10 still high", 32'(irq), 32'd1);
        check_irq_next("R10 low after edge");
        set_req(16'h0010);
        check_irq_next("R10 high again");
        set_en(4, 1'b0);
        #1; chk("R10 disable lag", 32'(irq), 32'd1);
        check_irq_next("R10 low after disable");
        set_en(4, 1'b1);
        check_irq_next("R10 high re-enabled");
        set_mask(4);
        #1; chk("R10 mask lag", 32'(irq), 32'd1);
        check_irq_next("R10 low after mask");
        set_mask(-1);

        // R11 and all others: pseudo-random mix against the scan model.
        for (int it = 0; it < 600; it++) begin
            logic [31:0] r = rnd();
            case (r % 5)
                0: set_en(int'((r >> 8) % N), 1'b1);
                1: set_en(int'((r >> 8) % N), 1'b0);
                2: set_mask(int'((r >> 8) % 17) - 1);
                3: put_prio(int'((r >> 8) % N), int'((r >> 16) % 16));
                default: set_req(N'(r >> 12));
            endcase
            check_vec("R11 random vector");
            check_irq_next("R10 random irq");
        end

        finish_run();
    end
endmodule